// File: doc/BRIEF.md
# Staged Reset Release Sequencer

This block turns one reset request, which arrives with no timing relation to the system clock, into a set of reset outputs that all follow that clock. The request passes through a chain of flip-flops before it can affect any other logic. While the synchronized request is high, every output is held in reset. Once it drops, the outputs are released one at a time. Each stage stays in reset for its own number of clock cycles, and those counts are set as top-level parameters. The stage counts are sized to cover minimum hold times such as a memory controller's power-up wait, which is 20000 cycles, or 200 µs at 100 MHz.

A stage starts counting only after the stage before it has been released, so the downstream subsystems leave reset in index order. A new request at any point clears every counter and puts every output back into reset. The synchronizer flops, counters and output flops all get their starting value at declaration. The outputs are therefore in reset from power-up, and the block needs no reset of its own. Every output comes straight from a flip-flop.

Top module: `rst_stage_sequencer`

## Requirements
- R1: The request is sampled by a chain of SYNC_STAGES flip-flops (default 2). A change on `rst_req_async` cannot reach `rst_out` before SYNC_STAGES+1 rising edges have passed. With the default, the outputs do not yet react after the second edge and do react after the third.
- R2: At power-up, before any clock edge, `rst_out` is all ones. A 1 means the stage is in reset, and bit i belongs to stage i.
- R3: Stage 0 is released (its bit goes to 0) on the rising edge SYNC_STAGES + D0 counted from the edge that first samples the request low. D0 is the low CNT_W bits of STAGE_CYCLES. This holds both after power-up and after every re-request.
- R4: Stage k (k ≥ 1) is released exactly Dk rising edges after the edge that released stage k−1. Dk is field k (bits k·CNT_W upward) of STAGE_CYCLES.
- R5: A stage with a higher index is never released while a stage with a lower index is still in reset.
- R6: On the first rising edge at which the synchronized request is high, all outputs return to 1 and all counters clear. This happens even for a request lasting one clock period. The following release then takes the full programmed time again.
- R7: Once released, a stage stays at 0 for as long as the request stays low. Its counter holds its terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all outputs are synchronous to it |
| rst_req_async | input | 1 | Reset request, active high, asynchronous to `clk` |
| rst_out | output | NUM_STAGES | Per-stage reset, active high, bit i = stage i |

## Verification
Two functions can fall in the same cycle. A new request can reach the counters on the very edge at which a stage would otherwise release or keep counting. The clear must win that edge.

The bench provokes this in two ways. It raises the request while stage 1 is mid-count. It also sends a one-period pulse just after stage 0 is released. In each case it checks that the outputs are unchanged after two edges and all ones after the third. It then checks that the next release takes the full programmed time, with no counts left over from before the request.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   // Shortest synchronizer chain accepted for the request input.
   localparam int unsigned MIN_SYNC_STAGES = 2;

   // True when value v can be held in an unsigned counter of w bits.
   function automatic bit fits_width(input longint unsigned v, input int unsigned w);
      return (v < (64'd1 << w));
   endfunction

   // True when a stage count is legal: at least one cycle, within the counter.
   function automatic bit stage_count_ok(input longint unsigned v, input int unsigned w);
      return (v >= 1) && fits_width(v - 1, w);
   endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic req_async,
   output logic req_sync
);
   import rst_seq_pkg::*;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
      $error("rst_seq_sync: SYNC_STAGES below minimum");
   end

   // Every flop powers up asserted, so the request reads high until the
   // chain has flushed a low level through.
   logic [SYNC_STAGES-1:0] chain_q = '1;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_flop
      if (g == 0) begin : g_first
         always_ff @(posedge clk) chain_q[0] <= req_async;
      end else begin : g_next
         always_ff @(posedge clk) chain_q[g] <= chain_q[g-1];
      end
   end

   assign req_sync = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/rst_seq_stage.sv
module rst_seq_stage #(
   parameter int unsigned     CNT_W = 16,
   parameter longint unsigned DELAY = 16
) (
   input  logic clk,
   input  logic clr_i,    // synchronized request: clear and hold in reset
   input  logic en_i,     // previous stage released (or request low for stage 0)
   output logic rst_o
);
   import rst_seq_pkg::*;

   if (!stage_count_ok(DELAY, CNT_W)) begin : g_bad_delay
      $error("rst_seq_stage: DELAY must be >= 1 and fit in CNT_W bits");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

   logic [CNT_W-1:0] cnt_q = '0;
   logic             rst_q = 1'b1;
   logic             hit;
   logic             armed_q = 1'b0;

   always_comb begin
      hit = en_i && rst_q && (cnt_q == LAST);
   end

   always_ff @(posedge clk) begin
      armed_q <= 1'b1;
      if (clr_i) begin
         cnt_q <= '0;
         rst_q <= 1'b1;
      end else if (en_i && rst_q) begin
         cnt_q <= hit ? cnt_q : cnt_q + 1'b1;   // saturate at the terminal count
         rst_q <= !hit;
      end
   end

   assign rst_o = rst_q;

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!armed_q)
      cnt_q <= LAST);                                                    // R3
   AST_RELEASE_NEEDS_PREV: assert property (@(posedge clk) disable iff (!armed_q)
      $fell(rst_q) |-> $past(en_i));                                     // R4
   AST_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!armed_q)
      (!rst_q && !clr_i) |=> !rst_q);                                    // R7

endmodule

// File: rtl/rst_stage_sequencer.sv
module rst_stage_sequencer #(
   parameter int unsigned NUM_STAGES  = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 16,
   // Field i (bits i*CNT_W upward) is the hold count of stage i.
   parameter logic [NUM_STAGES*CNT_W-1:0] STAGE_CYCLES = {16'd48, 16'd32, 16'd20000}
) (
   input  logic                  clk,
   input  logic                  rst_req_async,
   output logic [NUM_STAGES-1:0] rst_out
);

   if (NUM_STAGES < 1) begin : g_bad_stages
      $error("rst_stage_sequencer: NUM_STAGES must be at least 1");
   end

   logic req_sync;
   logic armed_q = 1'b0;

   always_ff @(posedge clk) armed_q <= 1'b1;

   rst_seq_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .req_async (rst_req_async),
      .req_sync  (req_sync)
   );

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      logic stage_en;

      if (i == 0) begin : g_head
         assign stage_en = !req_sync;
      end else begin : g_chain
         assign stage_en = !rst_out[i-1];
      end

      rst_seq_stage #(
         .CNT_W (CNT_W),
         .DELAY (longint'(STAGE_CYCLES[i*CNT_W +: CNT_W]))
      ) u_stage (
         .clk   (clk),
         .clr_i (req_sync),
         .en_i  (stage_en),
         .rst_o (rst_out[i])
      );

      if (i > 0) begin : g_order_chk
         AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!armed_q)
            !rst_out[i] |-> !rst_out[i-1]);                              // R5
      end
   end

   AST_REQUEST_CLEARS_ALL: assert property (@(posedge clk) disable iff (!armed_q)
      req_sync |=> (rst_out == '1));                                     // R6

endmodule

// File: tb/rst_stage_sequencer_bench.sv
module rst_stage_sequencer_bench;

   localparam int unsigned NS = 3;
   localparam int unsigned CW = 16;
   // Stage hold counts: stage0 = 4, stage1 = 6, stage2 = 3.
   localparam logic [NS*CW-1:0] CYC = {16'd3, 16'd6, 16'd4};

   logic          clk = 1'b0;
   logic          req = 1'b0;
   logic [NS-1:0] rst_out;
   int            checks = 0;
   int            errors = 0;

   always #5 clk = ~clk;

   rst_stage_sequencer #(
      .NUM_STAGES   (NS),
      .SYNC_STAGES  (2),
      .CNT_W        (CW),
      .STAGE_CYCLES (CYC)
   ) u_rst_stage_sequencer (
      .clk           (clk),
      .rst_req_async (req),
      .rst_out       (rst_out)
   );

   // {edges after request drops, expected rst_out}
   localparam logic [10:0] TBL [7] = '{
      {8'd5,  3'b111},   // R3 just before stage 0 release
      {8'd6,  3'b110},   // R3 stage 0 released at 2+4
      {8'd11, 3'b110},   // R4 R5 stage 1 still held
      {8'd12, 3'b100},   // R4 stage 1 released 6 edges later
      {8'd14, 3'b100},   // R5 stage 2 still held
      {8'd15, 3'b000},   // R4 stage 2 released 3 edges later
      {8'd20, 3'b000}    // R7 all stay released
   };

   task automatic check(input string tag, input logic [NS-1:0] exp);
      checks++;
      if (rst_out !== exp) begin
         errors++;
         $display("FAIL %s rst_out=%b expected=%b", tag, rst_out, exp);
      end
   endtask

   // Advance n rising edges, then settle 2 ns past the last one.
   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1;
      check("R2 power-up state", 3'b111);

      // Request held low from time zero.
      edges(5);
      check("R3 power-on before release", 3'b111);
      edges(1);
      check("R3 power-on stage 0 release", 3'b110);

      // Re-request while stage 1 counts.
      req = 1'b1;
      edges(2);
      check("R1 no reaction after two edges", 3'b110);
      edges(1);
      check("R6 all reasserted on third edge", 3'b111);
      edges(4);

      // Table walk of the full release sequence.
      req = 1'b0;
      begin
         int cur = 0;
         for (int k = 0; k < 7; k++) begin
            edges(int'(TBL[k][10:3]) - cur);
            cur = int'(TBL[k][10:3]);
            check($sformatf("R3/R4 table row %0d", k), TBL[k][2:0]);
         end
      end

      // Re-request after full release.
      req = 1'b1;
      edges(3);
      check("R6 reassert from released", 3'b111);
      edges(3);

      // Release, then one-period pulse just after stage 0 is out.
      req = 1'b0;
      edges(6);
      check("R3 released before pulse", 3'b110);
      req = 1'b1;
      edges(1);
      req = 1'b0;
      edges(1);
      check("R1 pulse not yet visible", 3'b110);
      edges(1);
      check("R6 one-period pulse reasserts all", 3'b111);
      edges(3);
      check("R6 counters cleared, stage 0 held", 3'b111);
      edges(1);
      check("R6 full count restarts stage 0", 3'b110);
      edges(5);
      check("R4 stage 1 held after restart", 3'b110);
      edges(1);
      check("R4 stage 1 release after restart", 3'b100);
      edges(3);
      check("R4 stage 2 release after restart", 3'b000);

      for (int k = 0; k < 10; k++) begin
         edges(3);
         check("R7 stays released", 3'b000);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule